// File: doc/BRIEF.md
# Dual Programmable PWM Time-Base Strobe Generator

This block produces two independent clock-enable strobes, A and B, from the master clock. PWM channel counters downstream use them as their time base. Each strobe has its own two-stage divider. The first stage is a free-running power-of-two prescaler. The second stage is a linear divider that counts prescaler ticks. The strobe period is therefore `2^exponent * divisor` master clock cycles. Every strobe is a pulse one master cycle wide; it is not a generated clock.

Both configurations live in one 32-bit mode register, written whole over a simple write port and readable at all times. The low half configures strobe A and the high half configures strobe B. A divisor field of zero keeps its strobe silent. A write restarts only the half whose value it changes, so software can retune one strobe without disturbing the phase of the other.

Top module: `pwm_clkgen`

## Requirements
- R1: After reset the mode register reads zero and neither strobe pulses.
- R2: A write with `wr_en` high loads all of `wr_data` into the mode register on that clock edge. `mode_q` shows the stored value from the next cycle onward. Without a write the register holds its value. Bits 15:0 configure strobe A and bits 31:16 configure strobe B. Within each half, bits 7:0 are the divisor and bits 15:8 are the prescale exponent.
- R3: With divisor d (1 to 255) and exponent e (0 to 10), the strobe pulses for exactly one cycle every `d * 2^e` cycles. The first pulse appears `d * 2^e - 1` cycles after the first cycle that shows the new value on `mode_q`.
- R4: Exponent 0 bypasses the prescaler, so the period is d. With d = 1 the strobe is high on every cycle.
- R5: A divisor field of zero gives no pulses, whatever the exponent is. This covers a half that is entirely zero.
- R6: An exponent above 10 behaves exactly like an exponent of 10.
- R7: A write that changes a half restarts that half's prescale and divide counters. A write that leaves a half's value unchanged does not alter that strobe's phase.
- R8: The two strobes are independent. The configuration and the restarts of one half never affect the other strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the mode register |
| wr_data | input | 32 | Value to store in the mode register |
| mode_q | output | 32 | Current mode register contents |
| tick_a | output | 1 | Strobe A, one-cycle enable pulse |
| tick_b | output | 1 | Strobe B, one-cycle enable pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor field, an 8-bit exponent field and a largest effective exponent of 10. These defaults make the clamped exponent range above 10 reachable, along with the longest period the bench can afford (3072 cycles). A behavioural model counts cycles since each half's last restart and predicts both strobes on every clock. Directed measurements cover first-pulse latency after a change, a phase-preserving rewrite of an unchanged half, and silence when the divisor is zero.

// File: rtl/pwm_clkgen.sv
module pwm_clkgen #(
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 8,
  parameter int EXP_MAX = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2*(DIV_W+EXP_W)-1:0]    wr_data,
  output logic [2*(DIV_W+EXP_W)-1:0]    mode_q,
  output logic                          tick_a,
  output logic                          tick_b
);
  localparam int HALF_W = DIV_W + EXP_W;
  localparam int REG_W  = 2 * HALF_W;
  localparam int PCNT_W = EXP_MAX;

  logic [REG_W-1:0] mode_r;
  logic [1:0]       tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     mode_r <= '0;
    else if (wr_en) mode_r <= wr_data;

  assign mode_q = mode_r;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] cur, nxt;
    logic [DIV_W-1:0]  div;
    logic [EXP_W-1:0]  ex;
    logic [PCNT_W-1:0] pcnt, mask;
    logic [DIV_W-1:0]  dcnt;
    logic              restart, active, pre_tick, last;

    assign cur      = mode_r[h*HALF_W +: HALF_W];
    assign nxt      = wr_data[h*HALF_W +: HALF_W];
    assign div      = cur[DIV_W-1:0];
    assign ex       = cur[HALF_W-1:DIV_W];
    assign restart  = wr_en && (nxt != cur);
    assign active   = div != '0;

    always_comb
      for (int i = 0; i < PCNT_W; i++)
        mask[i] = ex > EXP_W'(i);

    assign pre_tick = active && ((pcnt & mask) == mask);
    assign last     = dcnt == div - DIV_W'(1);
    assign tick[h]  = pre_tick && last;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pcnt <= '0;
        dcnt <= '0;
      end else if (restart || !active) begin
        pcnt <= '0;
        dcnt <= '0;
      end else begin
        pcnt <= pcnt + PCNT_W'(1);
        if (pre_tick) dcnt <= last ? '0 : dcnt + DIV_W'(1);
      end
  end

  assign tick_a = tick[0];
  assign tick_b = tick[1];
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] mode_q,
  input logic        tick_a,
  input logic        tick_b
);
  AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> mode_q == $past(wr_data)); // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(mode_q)); // R2
  AST_SILENT_A: assert property (@(posedge clk) disable iff (!rst_n) mode_q[7:0] == 8'h00 |-> !tick_a); // R5
  AST_SILENT_B: assert property (@(posedge clk) disable iff (!rst_n) mode_q[23:16] == 8'h00 |-> !tick_b); // R5
  AST_ONE_WIDE_A: assert property (@(posedge clk) disable iff (!rst_n) tick_a && !wr_en && mode_q[15:0] != 16'h0001 |=> !tick_a); // R3
  AST_ONE_WIDE_B: assert property (@(posedge clk) disable iff (!rst_n) tick_b && !wr_en && mode_q[31:16] != 16'h0001 |=> !tick_b); // R3
  AST_RESTART_A: assert property (@(posedge clk) disable iff (!rst_n) wr_en && wr_data[15:0] != mode_q[15:0] |=> !tick_a || mode_q[15:0] == 16'h0001); // R7
  AST_RESTART_B: assert property (@(posedge clk) disable iff (!rst_n) wr_en && wr_data[31:16] != mode_q[31:16] |=> !tick_b || mode_q[31:16] == 16'h0001); // R7
endmodule

bind pwm_clkgen pwm_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .mode_q(mode_q), .tick_a(tick_a), .tick_b(tick_b)
);

// File: tb/sim_pwm_clkgen.sv
`timescale 1ns/1ps
module sim_pwm_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] mode_q;
  logic        tick_a, tick_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_clkgen u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                 .mode_q(mode_q), .tick_a(tick_a), .tick_b(tick_b));

  logic [15:0] hv [2];
  longint      kc [2];

  function automatic bit predict(logic [15:0] v, longint k);
    longint d, e, p;
    d = v[7:0];
    e = (v[15:8] > 8'd10) ? 10 : v[15:8];
    if (d == 0) return 1'b0;
    p = d << e;
    return ((k + 1) % p) == 0;
  endfunction

  function automatic string tag(logic [15:0] v, int h);
    if (v[7:0] == 0) return "R5";
    if (v[15:8] > 8'd10) return "R6";
    if (v[15:8] == 0) return "R4";
    return (h == 1) ? "R8" : "R3";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin hv[h] = '0; kc[h] = 0; end
    end else begin
      for (int h = 0; h < 2; h++) begin
        logic [15:0] nv;
        nv = wr_en ? wr_data[h*16 +: 16] : hv[h];
        if (wr_en && nv != hv[h]) kc[h] = 0; else kc[h] = kc[h] + 1;
        hv[h] = nv;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(tick_a == predict(hv[0], kc[0]), tag(hv[0], 0), tick_a, predict(hv[0], kc[0]));
    check(tick_b == predict(hv[1], kc[1]), tag(hv[1], 1), tick_b, predict(hv[1], kc[1]));
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic [31:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic first_a(int expect_n, string req);
    int n = 0;
    while (!tick_a && n < 5000) begin @(negedge clk); n++; end
    check(n == expect_n, req, n, expect_n);
  endtask

  task automatic count_a(int cyc, int expect_n, string req);
    int n = 0;
    for (int i = 0; i < cyc; i++) begin n += tick_a; @(negedge clk); end
    check(n == expect_n, req, n, expect_n);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(mode_q == 32'h0, "R1", mode_q, 0);
    check(!tick_a && !tick_b, "R1", {tick_a, tick_b}, 0);
    run(20);
    write(32'h0205_0003);
    check(mode_q == 32'h0205_0003, "R2", mode_q, 32'h0205_0003);
    first_a(2, "R4");
    run(100);
    write(32'h0205_0101);
    first_a(1, "R3");
    run(60);
    write(32'h0205_0001);
    count_a(10, 10, "R4");
    write(32'h0000_0700);
    count_a(300, 0, "R5");
    check(!tick_b, "R5", tick_b, 0);
    write(32'h0A03_0B01);
    check(mode_q[31:16] == 16'h0A03 && mode_q[15:0] == 16'h0B01, "R2", mode_q, 32'h0A03_0B01);
    first_a(1023, "R6");
    run(1200);
    write(32'h0A03_0A01);
    first_a(1023, "R3");
    run(900);
    write(32'h0A03_0304);
    run(10);
    write(32'h0A03_0304);
    first_a(20, "R7");
    write(32'h0A03_0305);
    first_a(39, "R7");
    run(200);
    write(32'h0102_0304);
    check(mode_q[31:16] == 16'h0102, "R8", mode_q[31:16], 16'h0102);
    run(300);
    finish_run();
  end
endmodule